// File: doc/BRIEF.md
# Bit-Plane Signed Dot-Product Engine

This block computes one output of a convolution layer from a window of signed activations and a window of signed weights of the same shape. Neither operand is multiplied directly. Each is treated as a set of single-bit planes. For every pairing of an activation plane with a weight plane, the block ANDs the two planes across the whole window and counts the ones. It scales that count by a power of two given by the two plane positions and gives it a sign. Summing all of these terms yields the two's-complement dot product. A bias is then added and negative sums are clamped to zero.

Software first fills the weight store, one element per write, through a simple write port. It then presents the flattened activation window and a bias and pulses `start`. The block takes the operands in on that edge and works through one plane pair per clock. Sixteen cycles later it raises `done` for one cycle, together with the clamped result and the signed pre-activation sum. Both values hold until the next completion.

Top module: `dot_plane_engine`

## Requirements
- R1: While reset is held and on the cycle after it is released, `busy` and `done` are 0 and `result` and `raw_sum` are 0.
- R2: A write with `wr_en` high and `busy` low stores `wr_data` as the weight of element `wr_addr`. Element i of the window occupies bits [i*BITS +: BITS] of `act_vec`, and that activation is paired with weight i.
- R3: `raw_sum` equals the sum over all window elements of activation × weight, with both operands read as BITS-bit two's-complement values, plus the sign-extended `bias_in`. It does not overflow, including when every operand is −8.
- R4: `result` equals `raw_sum` when `raw_sum` is zero or positive, and 0 when it is negative. `result` is never negative.
- R5: A `start` sampled while idle is accepted. `busy` is high on the following cycle. `done` is high for exactly one cycle, BITS×BITS (16) cycles after the accepting edge, and `busy` falls in that same cycle.
- R6: A `start` that arrives while `busy` is high has no effect. The running operation keeps its operands and its timing, and no second `done` follows.
- R7: Weight writes attempted while `busy` is high are ignored. Both the current result and later operations use the previously stored weights.
- R8: `act_vec` and `bias_in` are captured on the accepting edge. Changing them during a run does not alter that run's result.
- R9: `result` and `raw_sum` change only in a cycle where `done` is high, and otherwise hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | $clog2(KSIZE*KSIZE*CHANS) | Window element index for the weight write |
| wr_data | input | BITS | Signed weight value to store |
| start | input | 1 | Begin an operation (taken only when idle) |
| act_vec | input | KSIZE*KSIZE*CHANS*BITS | Flattened signed activation window |
| bias_in | input | BIAS_W | Signed bias added to the sum |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| raw_sum | output | ACC_W | Signed sum before activation |
| result | output | ACC_W | Clamped (non-negative) output |

## Verification
On every cycle, the bound checker enforces the timing contract: the single-cycle done pulse, the exact latency counted from the accepting edge (which also catches a restart by a start during a run), the non-negative result, the clamping relation at completion, and output holding between completions. Only the bench scenarios can show that the arithmetic is correct. It compares against a behavioural multiply-accumulate over random and extreme operand sets, including all −8 values and large negative biases. The bench also covers behaviour that depends on what was stored or captured earlier: writes blocked while busy, and activations or bias changed mid-run.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dpe_state_e;

    // Width that holds N products of two BITS-bit signed values plus a bias.
    function automatic int unsigned acc_width(int unsigned n_elem,
                                              int unsigned bits,
                                              int unsigned bias_w);
        int unsigned prod_w;
        prod_w = $clog2(n_elem) + 2 * bits;
        return ((bias_w > prod_w) ? bias_w : prod_w) + 2;
    endfunction

    // A plane-pair term is negative when exactly one of the planes is the top one.
    function automatic logic term_negative(int unsigned m_idx,
                                           int unsigned n_idx,
                                           int unsigned bits);
        return (m_idx == bits - 1) ^ (n_idx == bits - 1);
    endfunction

endpackage

// File: rtl/dpe_weight_store.sv
module dpe_weight_store #(
    parameter int unsigned N_ELEM = 36,
    parameter int unsigned BITS   = 4,
    localparam int unsigned AW    = $clog2(N_ELEM)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [BITS-1:0]          wdata,
    output logic [N_ELEM*BITS-1:0]   wt_flat
);

    for (genvar i = 0; i < N_ELEM; i++) begin : g_cell
        logic [BITS-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (we && (waddr == AW'(i))) begin
                cell_q <= wdata;
            end
        end
        assign wt_flat[i*BITS +: BITS] = cell_q;
    end

endmodule

// File: rtl/dpe_plane_popcount.sv
module dpe_plane_popcount #(
    parameter int unsigned N_ELEM = 36,
    parameter int unsigned BITS   = 4,
    localparam int unsigned SW    = (BITS > 1) ? $clog2(BITS) : 1,
    localparam int unsigned CW    = $clog2(N_ELEM + 1)
) (
    input  logic [N_ELEM*BITS-1:0] act_flat,
    input  logic [N_ELEM*BITS-1:0] wt_flat,
    input  logic [SW-1:0]          m_sel,
    input  logic [SW-1:0]          n_sel,
    output logic [CW-1:0]          ones
);

    logic [N_ELEM-1:0] hit;

    for (genvar i = 0; i < N_ELEM; i++) begin : g_and
        logic [BITS-1:0] a_word;
        logic [BITS-1:0] w_word;
        assign a_word = act_flat[i*BITS +: BITS];
        assign w_word = wt_flat[i*BITS +: BITS];
        assign hit[i] = a_word[m_sel] & w_word[n_sel];
    end

    always_comb begin
        ones = '0;
        for (int j = 0; j < N_ELEM; j++) begin
            ones = ones + CW'(hit[j]);
        end
    end

endmodule

// File: rtl/dpe_sequencer.sv
module dpe_sequencer
    import dpe_pkg::*;
#(
    parameter int unsigned BITS = 4,
    localparam int unsigned SW  = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          accept,
    output logic          step_valid,
    output logic          step_last,
    output logic [SW-1:0] m_idx,
    output logic [SW-1:0] n_idx,
    output logic          busy
);

    dpe_state_e    state_q;
    logic [SW-1:0] m_q;
    logic [SW-1:0] n_q;

    assign busy       = (state_q == ST_RUN);
    assign accept     = start && (state_q == ST_IDLE);
    assign step_valid = busy;
    assign step_last  = busy && (m_q == SW'(BITS - 1)) && (n_q == SW'(BITS - 1));
    assign m_idx      = m_q;
    assign n_idx      = n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            m_q     <= '0;
            n_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        m_q     <= '0;
                        n_q     <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_last) begin
                        state_q <= ST_IDLE;
                        m_q     <= '0;
                        n_q     <= '0;
                    end else if (n_q == SW'(BITS - 1)) begin
                        n_q <= '0;
                        m_q <= m_q + 1'b1;
                    end else begin
                        n_q <= n_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dpe_accum.sv
module dpe_accum
    import dpe_pkg::*;
#(
    parameter int unsigned BITS   = 4,
    parameter int unsigned CW     = 6,
    parameter int unsigned BIAS_W = 16,
    parameter int unsigned ACC_W  = 18,
    localparam int unsigned SW    = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  logic [BIAS_W-1:0]       bias_in,
    input  logic                    step_valid,
    input  logic                    step_last,
    input  logic [SW-1:0]           m_idx,
    input  logic [SW-1:0]           n_idx,
    input  logic [CW-1:0]           ones,
    output logic                    done,
    output logic signed [ACC_W-1:0] raw_sum,
    output logic [ACC_W-1:0]        result
);

    logic signed [ACC_W-1:0] acc_q;
    logic [BIAS_W-1:0]       bias_q;
    logic [SW:0]             shamt;
    logic [ACC_W-1:0]        magnitude;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] bias_ext;
    logic signed [ACC_W-1:0] acc_next;
    logic signed [ACC_W-1:0] final_sum;

    assign shamt     = {1'b0, m_idx} + {1'b0, n_idx};
    assign magnitude = ACC_W'(ones) << shamt;
    assign term      = term_negative(int'(m_idx), int'(n_idx), BITS)
                       ? -$signed(magnitude) : $signed(magnitude);
    assign bias_ext  = $signed({{(ACC_W-BIAS_W){bias_q[BIAS_W-1]}}, bias_q});
    assign acc_next  = acc_q + term;
    assign final_sum = acc_next + bias_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            bias_q  <= '0;
            done    <= 1'b0;
            raw_sum <= '0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                acc_q  <= '0;
                bias_q <= bias_in;
            end else if (step_valid) begin
                acc_q <= acc_next;
                if (step_last) begin
                    raw_sum <= final_sum;
                    result  <= final_sum[ACC_W-1] ? '0 : final_sum;
                    done    <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dot_plane_engine.sv
module dot_plane_engine
    import dpe_pkg::*;
#(
    parameter int unsigned KSIZE  = 3,
    parameter int unsigned CHANS  = 4,
    parameter int unsigned BITS   = 4,
    parameter int unsigned BIAS_W = 16,
    localparam int unsigned N_ELEM = KSIZE * KSIZE * CHANS,
    localparam int unsigned AW     = $clog2(N_ELEM),
    localparam int unsigned ACC_W  = acc_width(N_ELEM, BITS, BIAS_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [BITS-1:0]         wr_data,
    input  logic                    start,
    input  logic [N_ELEM*BITS-1:0]  act_vec,
    input  logic [BIAS_W-1:0]       bias_in,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] raw_sum,
    output logic [ACC_W-1:0]        result
);

    localparam int unsigned SW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int unsigned CW = $clog2(N_ELEM + 1);

    logic                   accept;
    logic                   step_valid;
    logic                   step_last;
    logic [SW-1:0]          m_idx;
    logic [SW-1:0]          n_idx;
    logic [CW-1:0]          ones;
    logic [N_ELEM*BITS-1:0] wt_flat;
    logic [N_ELEM*BITS-1:0] act_q;
    logic                   store_we;

    assign store_we = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (accept) begin
            act_q <= act_vec;
        end
    end

    dpe_weight_store #(.N_ELEM(N_ELEM), .BITS(BITS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (store_we),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .wt_flat (wt_flat)
    );

    dpe_sequencer #(.BITS(BITS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .accept     (accept),
        .step_valid (step_valid),
        .step_last  (step_last),
        .m_idx      (m_idx),
        .n_idx      (n_idx),
        .busy       (busy)
    );

    dpe_plane_popcount #(.N_ELEM(N_ELEM), .BITS(BITS)) u_pop (
        .act_flat (act_q),
        .wt_flat  (wt_flat),
        .m_sel    (m_idx),
        .n_sel    (n_idx),
        .ones     (ones)
    );

    dpe_accum #(
        .BITS   (BITS),
        .CW     (CW),
        .BIAS_W (BIAS_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .bias_in    (bias_in),
        .step_valid (step_valid),
        .step_last  (step_last),
        .m_idx      (m_idx),
        .n_idx      (n_idx),
        .ones       (ones),
        .done       (done),
        .raw_sum    (raw_sum),
        .result     (result)
    );

endmodule

// File: rtl/dpe_checker.sv
module dpe_checker #(
    parameter int unsigned ACC_W = 18,
    parameter int unsigned LAT   = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic signed [ACC_W-1:0] raw_sum,
    input logic [ACC_W-1:0]        result
);

    // Edges since the last accepted start; a restart would reset it.
    logic [7:0] since_accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_accept <= '0;
        end else if (start && !busy) begin
            since_accept <= '0;
        end else if (busy && since_accept != 8'hFF) begin
            since_accept <= since_accept + 1'b1;
        end
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_on_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6: a start during a run must not restart the count.
    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_accept == 8'(LAT)));

    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
        !result[ACC_W-1]);

    assert_clamp_pos_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !raw_sum[ACC_W-1]) |-> (result == raw_sum));

    assert_clamp_neg_R4: assert property (@(posedge clk) disable iff (rst)
        (done && raw_sum[ACC_W-1]) |-> (result == '0));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    assert_raw_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(raw_sum) |-> done);

endmodule

bind dot_plane_engine dpe_checker #(
    .ACC_W (ACC_W),
    .LAT   (BITS * BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .raw_sum (raw_sum),
    .result  (result)
);

// File: tb/dot_plane_engine_bench.sv
module dot_plane_engine_bench;

    localparam int KSIZE  = 3;
    localparam int CHANS  = 4;
    localparam int BITS   = 4;
    localparam int BIAS_W = 16;
    localparam int N      = KSIZE * KSIZE * CHANS;
    localparam int AW     = $clog2(N);
    localparam int ACC_W  = 18;
    localparam int LAT    = BITS * BITS;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   wr_en = 1'b0;
    logic [AW-1:0]          wr_addr = '0;
    logic [BITS-1:0]        wr_data = '0;
    logic                   start = 1'b0;
    logic [N*BITS-1:0]      act_vec = '0;
    logic [BIAS_W-1:0]      bias_in = '0;
    logic                   busy;
    logic                   done;
    logic signed [ACC_W-1:0] raw_sum;
    logic [ACC_W-1:0]       result;

    int n_checks = 0;
    int n_errors = 0;
    int wmodel [N];
    int act_a  [N];
    int act_b  [N];

    always #2.5 clk = ~clk;

    dot_plane_engine u_dot_plane_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .act_vec(act_vec), .bias_in(bias_in),
        .busy(busy), .done(done), .raw_sum(raw_sum), .result(result)
    );

    task automatic chk(string req, longint got, longint exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(int a [N], int bias);
        int s = bias;
        for (int i = 0; i < N; i++) s += a[i] * wmodel[i];
        return s;
    endfunction

    function automatic int relu(int v);
        return (v < 0) ? 0 : v;
    endfunction

    task automatic write_w(int idx, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(idx); wr_data = BITS'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_weights(int mode);
        for (int i = 0; i < N; i++) begin
            int v;
            if (mode == 0) v = int'($urandom_range(15)) - 8;
            else if (mode == 1) v = -8;
            else v = 7;
            write_w(i, v);
            wmodel[i] = v;
        end
    endtask

    task automatic fill(ref int a [N], input int mode);
        for (int i = 0; i < N; i++)
            a[i] = (mode == 0) ? int'($urandom_range(15)) - 8 : -8;
    endtask

    task automatic drive_act(int a [N], int bias);
        for (int i = 0; i < N; i++) act_vec[i*BITS +: BITS] = BITS'(a[i]);
        bias_in = BIAS_W'(bias);
    endtask

    // Leaves the bench at the negedge just after the accepting edge.
    task automatic start_op(int a [N], int bias);
        @(negedge clk);
        drive_act(a, bias);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_out(string req, int exp);
        chk({req, " raw_sum"}, longint'($signed(raw_sum)), exp);
        chk({req, " result"}, longint'(result), relu(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        chk("R1 raw_sum", raw_sum, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after release", busy, 0);
        chk("R1 done after release", done, 0);
    endtask

    task automatic run_plain(string req, int a [N], int bias);
        int lat = 0;
        start_op(a, bias);
        chk({req, " R5 busy after accept"}, busy, 1);
        wait_done(lat);
        chk({req, " R5 latency"}, lat, LAT);
        chk({req, " R5 busy falls"}, busy, 0);
        check_out(req, model(a, bias));
        @(negedge clk);
        chk({req, " R5 done one cycle"}, done, 0);
    endtask

    task automatic t_random();
        load_weights(0);
        for (int r = 0; r < 6; r++) begin
            fill(act_a, 0);
            run_plain("R2 R3 random", act_a, int'($urandom_range(400)) - 200);
        end
    endtask

    task automatic t_corner();
        load_weights(1);
        fill(act_a, 1);
        run_plain("R3 all -8", act_a, 0);
        run_plain("R3 all -8 max bias", act_a, 32767);
        load_weights(2);
        run_plain("R3 R4 most negative", act_a, -32768);
        fill(act_a, 0);
        run_plain("R4 negative sum", act_a, -20000);
    endtask

    task automatic t_busy_start();
        int lat = 0;
        int dones = 0;
        load_weights(0);
        fill(act_a, 0);
        fill(act_b, 0);
        start_op(act_a, 55);
        for (int c = 0; c < 3; c++) begin @(negedge clk); lat++; end
        drive_act(act_b, -99);
        start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        wait_done(lat);
        chk("R6 latency unchanged", lat, LAT);
        check_out("R6 operands kept", model(act_a, 55));
        for (int c = 0; c < 24; c++) begin @(negedge clk); if (done) dones++; end
        chk("R6 no second done", dones, 0);
    endtask

    task automatic t_busy_write();
        int lat = 0;
        int exp;
        fill(act_a, 0);
        exp = model(act_a, 7);
        start_op(act_a, 7);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = BITS'(wmodel[i] ^ 5);
            @(negedge clk); lat++;
        end
        wr_en = 1'b0;
        wait_done(lat);
        check_out("R7 write during run", exp);
        run_plain("R7 weights kept", act_a, 7);
    endtask

    task automatic t_latch();
        int lat = 0;
        fill(act_a, 0);
        fill(act_b, 0);
        start_op(act_a, 300);
        @(negedge clk); lat++;
        drive_act(act_b, -300);
        wait_done(lat);
        check_out("R8 captured operands", model(act_a, 300));
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R9 result holds", $signed(raw_sum), model(act_a, 300));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_random();
        t_corner();
        t_busy_start();
        t_busy_write();
        t_latch();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule